// File: doc/BRIEF.md
# Fixed-Vector Interrupt Controller

This block collects five interrupt request sources and gives the instruction fetch unit one program address: the vector of the highest-priority request that is pending and enabled. The sources are two external request pins, two timer overflow pulses and one serial request. The serial request is the OR of the receive and transmit flags. Each source has its own enable bit, and a global enable gates all of them. Each external pin can run in one of two modes. In edge mode a rising edge sets a pending latch. In level mode the pin is used as it is.

The fetch unit raises `ack` in a cycle where `irq_valid` is high to accept the vector. The controller then enters the in-service state. While it is in service, no further vector is presented until the fetch unit pulses `reti`. Requests that arrive in the meantime stay pending. When no vector is valid, `vec_addr` carries the reset vector 0000h, which is where execution starts after reset.

Top module: `irqv_ctrl`

## Requirements
- R1: While reset is asserted and afterwards with no request, `irq_valid` is 0, `in_service` is 0 and `vec_addr` is 0000h.
- R2: A presented vector equals 0003h + 8 × index. The indices are INT0 = 0, TMR0 = 1, INT1 = 2, TMR1 = 3 and SER = 4, which gives 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R3: When several requests are eligible, the lowest index wins. The order is INT0, then TMR0, then INT1, then TMR1, then SER.
- R4: A source is eligible only when its enable bit `src_en[index]` is 1.
- R5: With `glob_en` at 0, no vector is presented, but latched requests are kept and appear once `glob_en` returns to 1.
- R6: An external pin in edge mode (`ext_edge_mode[n]` = 1) latches a rising edge at the clock edge that samples it. The request appears from that edge onward, persists after the pin falls, and clears when its vector is accepted.
- R7: An external pin in level mode (`ext_edge_mode[n]` = 0) requests directly from its current level, with no latch and no clock delay.
- R8: A one-cycle timer overflow pulse is latched at the clock edge and stays pending until its vector is accepted, which clears it.
- R9: The serial request is `ser_rx_req | ser_tx_req`. Acceptance does not clear it.
- R10: Accepting a vector (`irq_valid` and `ack`) sets `in_service` at the next edge. While `in_service` is 1, `irq_valid` stays 0 and requests remain pending.
- R11: A `reti` pulse clears `in_service` at the next clock edge, after which the highest pending request is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req | input | 2 | External request pins, [0] = INT0, [1] = INT1 |
| ext_edge_mode | input | 2 | 1 = rising-edge latched, 0 = level per external pin |
| tmr_ovf | input | 2 | Timer overflow pulses, [0] = TMR0, [1] = TMR1 |
| ser_rx_req | input | 1 | Serial receive request flag |
| ser_tx_req | input | 1 | Serial transmit request flag |
| src_en | input | 5 | Per-source enable, bit = source index |
| glob_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Fetch unit accepts the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_valid | output | 1 | A vector is being presented |
| vec_addr | output | 16 | Vector address, 0000h when none is valid |
| irq_src | output | 3 | Index of the presented source |
| in_service | output | 1 | An interrupt is being serviced |

## Verification
Two kinds of fault inside the block show up at the ports. A stuck pending latch shows as a vector that keeps coming back after acceptance and `reti`. A latch that is lost shows as `irq_valid` dropping once the pin has fallen. Either one is visible within one clock of the `reti` or of the pin change. A wrong in-service flag shows in the cycle after `ack` or `reti`, as `irq_valid` that fails to fall or fails to return. Errors in the priority and mask logic are purely combinational. They appear at once on `vec_addr`, so a sweep over every enable mask against every level-driven request pattern exposes them directly.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned SRC_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_INT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_INT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } irq_src_e;

  // Vector address of a source index: fixed base plus equal spacing.
  function automatic logic [31:0] vec_of(input logic [SRC_W-1:0] idx,
                                         input int unsigned base,
                                         input int unsigned stride);
    return 32'(base) + 32'(idx) * 32'(stride);
  endfunction
endpackage

// File: rtl/irqv_ext_src.sv
module irqv_ext_src (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_mode,
  input  logic clr,
  output logic req,
  output logic rose,
  output logic pend
);
  logic pin_q;

  assign rose = pin & ~pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pin_q <= pin;
      if (!edge_mode)  pend <= 1'b0;
      else if (rose)   pend <= 1'b1;
      else if (clr)    pend <= 1'b0;
    end
  end

  assign req = edge_mode ? pend : pin;
endmodule

// File: rtl/irqv_pulse_latch.sv
module irqv_pulse_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (pulse)  pend <= 1'b1;
    else if (clr)    pend <= 1'b0;
  end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/irqv_service.sv
module irqv_service (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic reti,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy <= 1'b0;
    else if (take)  busy <= 1'b1;
    else if (reti)  busy <= 1'b0;
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8,
  parameter int unsigned RESET_VEC  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ext_req,
  input  logic [1:0]        ext_edge_mode,
  input  logic [1:0]        tmr_ovf,
  input  logic              ser_rx_req,
  input  logic              ser_tx_req,
  input  logic [NSRC-1:0]   src_en,
  input  logic              glob_en,
  input  logic              ack,
  input  logic              reti,
  output logic              irq_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [SRC_W-1:0]  irq_src,
  output logic              in_service
);
  localparam int unsigned NPAIR = 2;

  logic [NSRC-1:0]  raw_req;
  logic [NSRC-1:0]  elig;
  logic [NSRC-1:0]  grant;
  logic [NSRC-1:0]  clr;
  logic [NPAIR-1:0] ext_rose;
  logic [NPAIR-1:0] ext_pend;
  logic [SRC_W-1:0] win_idx;
  logic             any_elig;
  logic             take;

  // Sources alternate external / timer: INT0, TMR0, INT1, TMR1.
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    irqv_ext_src u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (ext_req[g]),
      .edge_mode (ext_edge_mode[g]),
      .clr       (clr[2*g]),
      .req       (raw_req[2*g]),
      .rose      (ext_rose[g]),
      .pend      (ext_pend[g])
    );
    irqv_pulse_latch u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .pulse (tmr_ovf[g]),
      .clr   (clr[2*g+1]),
      .pend  (raw_req[2*g+1])
    );
  end

  // Serial flags are owned by the serial logic and never cleared here.
  assign raw_req[SRC_SER] = ser_rx_req | ser_tx_req;

  assign elig = raw_req & src_en;

  irqv_prio #(.N(NSRC), .IW(SRC_W)) u_prio (
    .req   (elig),
    .grant (grant),
    .idx   (win_idx),
    .any   (any_elig)
  );

  assign irq_valid = any_elig & glob_en & ~in_service;
  assign take      = irq_valid & ack;
  assign clr       = take ? grant : '0;
  assign irq_src   = win_idx;
  assign vec_addr  = irq_valid ? ADDR_W'(vec_of(win_idx, VEC_BASE, VEC_STRIDE))
                               : ADDR_W'(RESET_VEC);

  irqv_service u_svc (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .reti  (reti),
    .busy  (in_service)
  );
endmodule

// File: rtl/irqv_ctrl_chk.sv
module irqv_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_en,
  input logic              ack,
  input logic              reti,
  input logic              irq_valid,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              in_service,
  input logic              take,
  input logic [N-1:0]      grant,
  input logic [1:0]        ext_edge_mode,
  input logic [1:0]        ext_rose,
  input logic [1:0]        ext_pend
);
  a_r1_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> vec_addr == '0);

  a_r2_vector_grid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (vec_addr[2:0] == 3'b011) && (vec_addr <= ADDR_W'(16'h0023)));

  a_r3_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $countones(grant) == 1);

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> glob_en);

  a_r6_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && grant[0] && ext_edge_mode[0] && !ext_rose[0]) |=> !ext_pend[0]);

  a_r10_take_sets: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> in_service);

  a_r10_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    in_service |-> !irq_valid);

  a_r11_reti_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take) |=> !in_service);
endmodule

bind irqv_ctrl irqv_ctrl_chk #(.ADDR_W(ADDR_W), .N(irqv_pkg::NSRC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .glob_en       (glob_en),
  .ack           (ack),
  .reti          (reti),
  .irq_valid     (irq_valid),
  .vec_addr      (vec_addr),
  .in_service    (in_service),
  .take          (take),
  .grant         (grant),
  .ext_edge_mode (ext_edge_mode),
  .ext_rose      (ext_rose),
  .ext_pend      (ext_pend)
);

// File: tb/irqv_ctrl_tb.sv
module irqv_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_req = '0;
  logic [1:0]  ext_edge_mode = '0;
  logic [1:0]  tmr_ovf = '0;
  logic        ser_rx_req = 1'b0;
  logic        ser_tx_req = 1'b0;
  logic [4:0]  src_en = '0;
  logic        glob_en = 1'b0;
  logic        ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq_valid;
  logic [15:0] vec_addr;
  logic [2:0]  irq_src;
  logic        in_service;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqv_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .ext_req (ext_req), .ext_edge_mode (ext_edge_mode),
    .tmr_ovf (tmr_ovf), .ser_rx_req (ser_rx_req), .ser_tx_req (ser_tx_req),
    .src_en (src_en), .glob_en (glob_en), .ack (ack), .reti (reti),
    .irq_valid (irq_valid), .vec_addr (vec_addr), .irq_src (irq_src),
    .in_service (in_service)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected vector: index in bits [5:3], low bits fixed at 3'b011.
  function automatic logic [15:0] exp_vec(input logic [4:0] req);
    for (int i = 0; i < 5; i++)
      if (req[i]) return {10'd0, 3'(i), 3'b011};
    return 16'h0000;
  endfunction

  task automatic accept();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic do_reti();
    @(negedge clk) reti = 1'b1;
    @(negedge clk) reti = 1'b0;
  endtask

  initial begin
    #1;
    check("R1 valid in reset", {15'd0, irq_valid}, 16'd0);
    check("R1 vector in reset", vec_addr, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_service after reset", {15'd0, in_service}, 16'd0);
    check("R1 vector after reset", vec_addr, 16'h0000);

    // Sweep: level externals and serial against every enable mask.
    glob_en = 1'b1;
    for (int m = 0; m < 32; m++) begin
      for (int p = 0; p < 8; p++) begin
        logic [4:0] r;
        @(negedge clk);
        src_en = 5'(m);
        ext_req = p[1:0];
        ser_rx_req = p[2] & ~m[0];
        ser_tx_req = p[2] & m[0];
        r = {p[2], 1'b0, p[1], 1'b0, p[0]} & 5'(m);
        #1;
        check("R2 R3 R4 R7 R9 sweep vector", vec_addr, exp_vec(r));
        check("R4 R7 sweep valid", {15'd0, irq_valid}, {15'd0, |r});
      end
    end
    @(negedge clk);
    glob_en = 1'b0; ext_req = 2'b11; src_en = 5'h1F;
    #1;
    check("R5 global off valid", {15'd0, irq_valid}, 16'd0);
    check("R5 global off vector", vec_addr, 16'h0000);
    ext_req = '0; ser_rx_req = 1'b0; ser_tx_req = 1'b0; glob_en = 1'b1;

    // Timer latch, priority against a level pin, in-service blocking.
    @(negedge clk) tmr_ovf = 2'b10;
    #1 check("R8 pulse not visible before edge", {15'd0, irq_valid}, 16'd0);
    @(negedge clk) tmr_ovf = 2'b00;
    #1 check("R8 TMR1 latched", vec_addr, 16'h001B);
    ext_req[1] = 1'b1;
    #1 check("R3 INT1 above TMR1", vec_addr, 16'h0013);
    accept();
    check("R10 in_service set", {15'd0, in_service}, 16'd1);
    check("R10 blocked while in service", {15'd0, irq_valid}, 16'd0);
    ext_req[1] = 1'b0;
    do_reti();
    check("R11 in_service cleared", {15'd0, in_service}, 16'd0);
    check("R10 TMR1 kept pending", vec_addr, 16'h001B);
    accept();
    do_reti();
    check("R8 TMR1 cleared by accept", {15'd0, irq_valid}, 16'd0);

    // TMR0 pulse versus INT1 level.
    @(negedge clk) begin tmr_ovf = 2'b01; ext_req[1] = 1'b1; end
    @(negedge clk) tmr_ovf = 2'b00;
    #1 check("R3 TMR0 above INT1", vec_addr, 16'h000B);
    accept(); do_reti();
    check("R8 R3 INT1 after TMR0 served", vec_addr, 16'h0013);
    ext_req[1] = 1'b0;

    // Serial not auto-cleared.
    @(negedge clk) ser_tx_req = 1'b1;
    #1 check("R9 serial vector", vec_addr, 16'h0023);
    accept(); do_reti();
    check("R9 serial still requesting", vec_addr, 16'h0023);
    ser_tx_req = 1'b0;
    #1 check("R9 serial gone after flag drop", {15'd0, irq_valid}, 16'd0);

    // Edge mode on INT0.
    @(negedge clk) ext_edge_mode = 2'b01;
    @(negedge clk) ext_req[0] = 1'b1;
    #1 check("R6 edge not visible before clock", {15'd0, irq_valid}, 16'd0);
    @(negedge clk) ext_req[0] = 1'b0;
    #1 check("R6 edge latched after pin falls", vec_addr, 16'h0003);
    accept(); do_reti();
    check("R6 edge pending cleared", {15'd0, irq_valid}, 16'd0);

    // Edge latched with global enable off, kept until enabled.
    @(negedge clk) begin glob_en = 1'b0; ext_req[0] = 1'b1; end
    @(negedge clk) ext_req[0] = 1'b0;
    @(negedge clk);
    check("R5 latched but gated", {15'd0, irq_valid}, 16'd0);
    glob_en = 1'b1;
    #1 check("R5 R6 latched request appears", vec_addr, 16'h0003);
    check("R2 source index", {13'd0, irq_src}, 16'd0);
    accept(); do_reti();

    // Level INT0 held high while in level mode: not latched.
    @(negedge clk) begin ext_edge_mode = 2'b00; ext_req[0] = 1'b1; end
    #1 check("R7 level immediate", vec_addr, 16'h0003);
    ext_req[0] = 1'b0;
    #1 check("R7 level gone at once", {15'd0, irq_valid}, 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule